// File: doc/BRIEF.md
# Predicated Fixed-Point Execution Unit

This block is one 32-bit fixed-point execution slot of a DSP data path. Each issued operation carries an opcode, two 32-bit source operands and a predicate bit. The unit computes one of nine operations:

- a wrapping add
- a clamping signed add
- a two-lane packed halfword add
- one step of a restoring division
- four halfword multiplies (low or high halves, signed or unsigned)
- a full-width multiply that keeps the low word

It reports a result word, a write-enable for the destination register, and a flag that marks when clamping took place.

Operand fetch, decode and the register file sit outside the block. The caller presents an operation with `in_valid` high. When the output stage is enabled by the `REG_OUT` parameter, the answer appears on the cycle after the issuing clock edge. A false predicate or an unassigned opcode turns the slot into a no-op: nothing is written and no flag is raised. Repeating the division step, feeding the result back in as the first source, performs an unsigned division one quotient bit per step.

Top module: `dsp_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `wr_en`, `sat_flag` and `result` are all zero after that edge. With `REG_OUT=1`, outputs reflect the inputs sampled at the previous clock edge.
- R2: If `in_valid` or `pred` is low, `wr_en` and `sat_flag` are 0 and `result` is 0, whatever the opcode and operands.
- R3: Opcode 2 (packed add) sets bits 15:0 to the low-half sum modulo 2^16 and bits 31:16 to the high-half sum modulo 2^16. No carry crosses from bit 15 into bit 16.
- R4: Opcode 1 (clamping add) returns the signed sum when it fits. On positive overflow it returns 0x7FFFFFFF and on negative overflow it returns 0x80000000. `sat_flag` is 1 exactly when clamping occurred.
- R5: Opcode 0 (plain add) returns the sum modulo 2^32 and never sets `sat_flag`.
- R6: Opcode 3 (division step), comparing sources as unsigned values: if src_a >= src_b, the result is ((src_a - src_b) << 1) | 1; otherwise it is src_a << 1.
- R7: Opcodes 4 (signed) and 5 (unsigned) return the full 32-bit product of the low halfwords, sign- or zero-extended respectively.
- R8: Opcodes 6 (signed) and 7 (unsigned) return the full 32-bit product of the high halfwords, sign- or zero-extended respectively.
- R9: Opcode 8 returns the low 32 bits of the 32x32 product.
- R10: Opcodes 9 to 15 are unassigned. With `in_valid` and `pred` high they give `wr_en`=0, `result`=0 and `sat_flag`=0, while `out_valid` still follows `in_valid`.
- R11: This case assumes a 16-bit dividend and a nonzero 16-bit divisor. Start from the dividend and use the divisor shifted left by 15 as src_b. Applying opcode 3 sixteen times, each time feeding the result back as src_a, leaves the quotient in bits 15:0 and the remainder in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| pred | input | 1 | Predicate; low cancels the operation |
| op | input | 4 | Operation code |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| out_valid | output | 1 | Output slot carries an issued operation |
| wr_en | output | 1 | Destination write enable |
| result | output | 32 | Result word |
| sat_flag | output | 1 | Clamping occurred in the clamping add |

## Verification
The checker assumes that `op`, `src_a`, `src_b`, `pred` and `in_valid` are known (not X) at every clock edge once reset is released. It also assumes that the reset pulse lasts at least one edge, so its delayed copies of the inputs line up with the output stage. The bench keeps within this:

- It drives every input to a defined value from time zero.
- It changes inputs only on the falling clock edge.
- It holds reset over several edges.
- It returns `in_valid` low between scenarios.

// File: rtl/dsp_exec_pkg.sv
package dsp_exec_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_SADD   = 4'd1,
    OP_ADD2   = 4'd2,
    OP_DSTEP  = 4'd3,
    OP_MLO_S  = 4'd4,
    OP_MLO_U  = 4'd5,
    OP_MHI_S  = 4'd6,
    OP_MHI_U  = 4'd7,
    OP_MUL32  = 4'd8
  } op_t;

  localparam logic [OP_W-1:0] OP_LAST = 4'd8;

endpackage

// File: rtl/dsp_exec_addsub.sv
module dsp_exec_addsub #(
  parameter int DW    = 32,
  parameter int LANES = 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] add_res,
  output logic [DW-1:0] sadd_res,
  output logic          sadd_clamp,
  output logic [DW-1:0] add2_res,
  output logic [DW-1:0] dstep_res
);

  localparam int LW = DW / LANES;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] sum;
  logic [DW-1:0] diff;
  logic          a_ge_b;

  assign sum     = a + b;
  assign add_res = sum;

  // signed overflow: like-signed inputs producing an opposite-signed sum
  always_comb begin
    sadd_clamp = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
    if (sadd_clamp) sadd_res = a[DW-1] ? SMIN : SMAX;
    else            sadd_res = sum;
  end

  // independent lane adders, no carry between lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign add2_res[g*LW +: LW] = a[g*LW +: LW] + b[g*LW +: LW];
  end

  // restoring division step with unsigned comparison
  assign a_ge_b = (a >= b);
  assign diff   = a - b;
  always_comb begin
    if (a_ge_b) dstep_res = (diff << 1) | {{(DW-1){1'b0}}, 1'b1};
    else        dstep_res = a << 1;
  end

endmodule

// File: rtl/dsp_exec_mul.sv
module dsp_exec_mul #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]               a,
  input  logic [DW-1:0]               b,
  // index [half][signed] : half 0 = low, 1 = high; signed 0 = unsigned
  output logic [1:0][1:0][DW-1:0]     half_prod,
  output logic [DW-1:0]               full_prod
);

  localparam int HW = DW / 2;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] ha;
    logic [HW-1:0] hb;
    assign ha = a[h*HW +: HW];
    assign hb = b[h*HW +: HW];
    for (genvar s = 0; s < 2; s++) begin : g_sign
      logic [DW-1:0] ext_a;
      logic [DW-1:0] ext_b;
      // extension to full width: low word of product equals exact product
      assign ext_a = {{HW{(s == 1) & ha[HW-1]}}, ha};
      assign ext_b = {{HW{(s == 1) & hb[HW-1]}}, hb};
      assign half_prod[h][s] = ext_a * ext_b;
    end
  end

  assign full_prod = a * b;

endmodule

// File: rtl/dsp_exec_outstage.sv
module dsp_exec_outstage #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_in,
  input  logic          we_in,
  input  logic [DW-1:0] res_in,
  input  logic          sat_in,
  output logic          v_out,
  output logic          we_out,
  output logic [DW-1:0] res_out,
  output logic          sat_out
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_out   <= 1'b0;
        we_out  <= 1'b0;
        res_out <= '0;
        sat_out <= 1'b0;
      end else begin
        v_out   <= v_in;
        we_out  <= we_in;
        res_out <= res_in;
        sat_out <= sat_in;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign v_out   = v_in;
    assign we_out  = we_in;
    assign res_out = res_in;
    assign sat_out = sat_in;
  end

endmodule

// File: rtl/dsp_exec_unit.sv
module dsp_exec_unit
  import dsp_exec_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            pred,
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  output logic            out_valid,
  output logic            wr_en,
  output logic [DW-1:0]   result,
  output logic            sat_flag
);

  logic [DW-1:0]           add_res, sadd_res, add2_res, dstep_res, full_prod;
  logic                    sadd_clamp;
  logic [1:0][1:0][DW-1:0] half_prod;

  logic                    fire;
  logic                    legal;
  logic [DW-1:0]           sel_res;
  logic                    sel_sat;
  logic [DW-1:0]           nxt_res;
  logic                    nxt_we;
  logic                    nxt_sat;

  dsp_exec_addsub #(.DW(DW), .LANES(2)) u_addsub (
    .a          (src_a),
    .b          (src_b),
    .add_res    (add_res),
    .sadd_res   (sadd_res),
    .sadd_clamp (sadd_clamp),
    .add2_res   (add2_res),
    .dstep_res  (dstep_res)
  );

  dsp_exec_mul #(.DW(DW)) u_mul (
    .a         (src_a),
    .b         (src_b),
    .half_prod (half_prod),
    .full_prod (full_prod)
  );

  always_comb begin
    legal   = 1'b1;
    sel_sat = 1'b0;
    sel_res = '0;
    case (op)
      OP_ADD:   sel_res = add_res;
      OP_SADD: begin
        sel_res = sadd_res;
        sel_sat = sadd_clamp;
      end
      OP_ADD2:  sel_res = add2_res;
      OP_DSTEP: sel_res = dstep_res;
      OP_MLO_S: sel_res = half_prod[0][1];
      OP_MLO_U: sel_res = half_prod[0][0];
      OP_MHI_S: sel_res = half_prod[1][1];
      OP_MHI_U: sel_res = half_prod[1][0];
      OP_MUL32: sel_res = full_prod;
      default:  legal   = 1'b0;
    endcase
  end

  // predicate gate: a cancelled slot writes nothing and reports nothing
  assign fire    = in_valid & pred & legal;
  assign nxt_we  = fire;
  assign nxt_res = fire ? sel_res : '0;
  assign nxt_sat = fire & sel_sat;

  dsp_exec_outstage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .v_in    (in_valid),
    .we_in   (nxt_we),
    .res_in  (nxt_res),
    .sat_in  (nxt_sat),
    .v_out   (out_valid),
    .we_out  (wr_en),
    .res_out (result),
    .sat_out (sat_flag)
  );

endmodule

// File: rtl/dsp_exec_unit_chk.sv
module dsp_exec_unit_chk
  import dsp_exec_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            pred,
  input logic [OP_W-1:0] op,
  input logic [DW-1:0]   src_a,
  input logic [DW-1:0]   src_b,
  input logic            out_valid,
  input logic            wr_en,
  input logic [DW-1:0]   result,
  input logic            sat_flag
);

  localparam int HW = DW / 2;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic            d_valid, d_pred;
  logic [OP_W-1:0] d_op;
  logic [DW-1:0]   d_a, d_b;

  // align the inputs with the output stage
  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        d_valid <= 1'b0;
        d_pred  <= 1'b0;
        d_op    <= '0;
        d_a     <= '0;
        d_b     <= '0;
      end else begin
        d_valid <= in_valid;
        d_pred  <= pred;
        d_op    <= op;
        d_a     <= src_a;
        d_b     <= src_b;
      end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && !wr_en && !sat_flag && result == '0));
  end else begin : g_nodly
    assign d_valid = in_valid;
    assign d_pred  = pred;
    assign d_op    = op;
    assign d_a     = src_a;
    assign d_b     = src_b;
  end

  logic [HW-1:0] lo_sum, hi_sum;
  always_comb begin
    lo_sum = d_a[HW-1:0] + d_b[HW-1:0];
    hi_sum = d_a[DW-1:HW] + d_b[DW-1:HW];
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == d_valid);

  assert_cancel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(d_valid && d_pred) |-> (!wr_en && !sat_flag && result == '0));

  assert_lanes_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && d_op == OP_ADD2) |-> (result[HW-1:0] == lo_sum && result[DW-1:HW] == hi_sum));

  assert_clamp_value_R4: assert property (@(posedge clk) disable iff (rst)
    sat_flag |-> (wr_en && d_op == OP_SADD && (result == SMAX || result == SMIN)));

  assert_wrap_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && d_op == OP_ADD) |-> (!sat_flag && result == d_a + d_b));

  assert_step_bit0_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && d_op == OP_DSTEP) |-> (result[0] == (d_a >= d_b)));

  assert_unassigned_R10: assert property (@(posedge clk) disable iff (rst)
    (d_op > OP_LAST) |-> (!wr_en && !sat_flag && result == '0));

endmodule

bind dsp_exec_unit dsp_exec_unit_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .pred      (pred),
  .op        (op),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .result    (result),
  .sat_flag  (sat_flag)
);

// File: tb/dsp_exec_unit_tb.sv
`timescale 1ns/1ps
module dsp_exec_unit_tb;
  import dsp_exec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        pred = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid, wr_en, sat_flag;
  logic [31:0] result;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dsp_exec_unit #(.DW(32), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred(pred), .op(op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .wr_en(wr_en),
    .result(result), .sat_flag(sat_flag)
  );

  // behavioural model
  function automatic void model(input logic [3:0] o, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] r,
                                output logic s, output logic w);
    longint sa, sb, sum;
    s = 1'b0; w = 1'b1; r = '0;
    case (o)
      4'd0: r = 32'((longint'(a) + longint'(b)) % 64'h1_0000_0000);
      4'd1: begin
        sa = longint'($signed(a)); sb = longint'($signed(b)); sum = sa + sb;
        if (sum > 64'sd2147483647)       begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (sum < -64'sd2147483648) begin r = 32'h8000_0000; s = 1'b1; end
        else r = 32'(sum);
      end
      4'd2: begin r[15:0] = a[15:0] + b[15:0]; r[31:16] = a[31:16] + b[31:16]; end
      4'd3: r = (a >= b) ? (((a - b) << 1) | 32'd1) : (a << 1);
      4'd4: r = 32'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
      4'd5: r = 32'(longint'(a[15:0]) * longint'(b[15:0]));
      4'd6: r = 32'(longint'($signed(a[31:16])) * longint'($signed(b[31:16])));
      4'd7: r = 32'(longint'(a[31:16]) * longint'(b[31:16]));
      4'd8: r = 32'(longint'(a) * longint'(b));
      default: w = 1'b0;
    endcase
  endfunction

  task automatic issue(input logic v, input logic p, input logic [3:0] o,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = v; pred = p; op = o; src_a = a; src_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ev, input logic ew,
                       input logic [31:0] er, input logic es);
    n_chk++;
    if (out_valid !== ev || wr_en !== ew || result !== er || sat_flag !== es) begin
      n_err++;
      $display("FAIL %s: got v=%0b w=%0b r=%h s=%0b, expected v=%0b w=%0b r=%h s=%0b",
               tag, out_valid, wr_en, result, sat_flag, ev, ew, er, es);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] o,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r; logic s, w;
    model(o, a, b, r, s, w);
    issue(1'b1, 1'b1, o, a, b);
    check(tag, 1'b1, w, w ? r : 32'd0, s);
  endtask

  task automatic t_reset;
    check("R1 reset state", 1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_predicate;
    issue(1'b1, 1'b0, 4'd1, 32'h7FFF_FFFF, 32'd1);
    check("R2 false predicate", 1'b1, 1'b0, 32'd0, 1'b0);
    issue(1'b0, 1'b1, 4'd0, 32'd3, 32'd4);
    check("R2 no issue", 1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  task automatic t_add;
    run_op("R5 wrap add", 4'd0, 32'hFFFF_FFFF, 32'd2);
    run_op("R5 overflowing add no flag", 4'd0, 32'h7FFF_FFFF, 32'd1);
  endtask

  task automatic t_sadd;
    run_op("R4 positive clamp", 4'd1, 32'h7FFF_FFFF, 32'd1);
    run_op("R4 negative clamp", 4'd1, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R4 in range", 4'd1, 32'd5, 32'hFFFF_FFFD);
    run_op("R4 mixed signs at edge", 4'd1, 32'h8000_0000, 32'h7FFF_FFFF);
  endtask

  task automatic t_add2;
    run_op("R3 low carry isolated", 4'd2, 32'h0001_FFFF, 32'h0001_0001);
    run_op("R3 both halves wrap", 4'd2, 32'hFFFF_8000, 32'h0002_8000);
  endtask

  task automatic t_dstep;
    run_op("R6 subtract taken", 4'd3, 32'd100, 32'd30);
    run_op("R6 unsigned compare", 4'd3, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op("R6 not taken", 4'd3, 32'd5, 32'd9);
    run_op("R6 equal", 4'd3, 32'd7, 32'd7);
  endtask

  task automatic t_mpy;
    run_op("R7 signed low", 4'd4, 32'h1234_FFFE, 32'hABCD_0003);
    run_op("R7 unsigned low", 4'd5, 32'h1234_FFFE, 32'hABCD_0003);
    run_op("R7 signed low extremes", 4'd4, 32'h0000_8000, 32'h0000_8000);
    run_op("R8 signed high", 4'd6, 32'hFFF0_1111, 32'h0010_2222);
    run_op("R8 unsigned high", 4'd7, 32'hFFFF_0000, 32'hFFFF_0000);
    run_op("R9 full multiply low word", 4'd8, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op("R9 negative times negative", 4'd8, 32'hFFFF_FFFD, 32'hFFFF_FFF9);
  endtask

  task automatic t_unassigned;
    for (int k = 9; k < 16; k++) begin
      issue(1'b1, 1'b1, 4'(k), 32'h1111_1111, 32'h2222_2222);
      check("R10 unassigned opcode", 1'b1, 1'b0, 32'd0, 1'b0);
    end
  endtask

  task automatic t_divide(input logic [15:0] num, input logic [15:0] den);
    logic [31:0] acc;
    logic [31:0] exp;
    acc = {16'd0, num};
    for (int i = 0; i < 16; i++) begin
      issue(1'b1, 1'b1, 4'd3, acc, {1'b0, den, 15'd0});
      acc = result;
    end
    exp = {16'(num % den), 16'(num / den)};
    check("R11 iterated division", 1'b1, 1'b1, exp, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_predicate();
    t_add();
    t_sadd();
    t_add2();
    t_dstep();
    t_mpy();
    t_unassigned();
    t_divide(16'd100, 16'd7);
    t_divide(16'd65535, 16'd255);
    t_divide(16'd3, 16'd9);
    issue(1'b0, 1'b0, 4'd0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule